// File: doc/BRIEF.md
# Capture and Edge-Count Unit

This block is the input side of a general-purpose timer. Four external capture pins are brought into the clock domain, and edges on them are detected. The block owns the shared timer counter. In timer mode the counter advances on a step pulse from an external prescaler. In counter mode it advances on the rising edges, the falling edges or both edges of one chosen pin, and while that is the case the prescaler is told to hold at zero.

In every mode, each pin can copy the counter into its own capture register when a chosen edge arrives. It can also raise a capture flag, which software clears by writing a one to it. A small register interface holds the count-mode field and the capture controls, and it lets software read the captures and the flags.

Each pin runs through a two-flop synchronizer. Its sampled level is then tracked by a two-state machine with the states LV_LOW and LV_HIGH. The transition LV_LOW to LV_HIGH is the rise event, and the transition LV_HIGH to LV_LOW is the fall event. When the sample matches the state, the machine stays where it is and no event occurs.

Top module: `tcap_unit`

## Requirements
- R1: After reset, `tc_value` is 0, `presc_hold` and `cap_irq` are 0, and every readable address returns 0.
- R2: With mode field bits 1:0 = 00 (timer mode), `tc_value` rises by one after each clock edge at which `cnt_en` and `presc_tick` are both high.
- R3: `presc_hold` is 1 exactly when mode bits 1:0 are not 00. In those modes `presc_tick` has no effect on `tc_value`.
- R4: Mode bits 1:0 = 01, 10 or 11 count the rising edges, the falling edges or both edges of the pin chosen by mode bits 3:2. A level applied before clock edge k shows in `tc_value` after edge k+2, and each detected edge gives at most one count.
- R5: In counter mode, edges on pins other than the selected one leave `tc_value` unchanged.
- R6: While `cnt_en` is low, `tc_value` holds. `cnt_clr` zeroes `tc_value` at the next edge and takes priority over any count.
- R7: Capture control bit 3i enables capture of pin i on a rising edge, and bit 3i+1 enables it on a falling edge. A capture stores the `tc_value` held before the edge at which the event is seen, even when a count happens at that same edge.
- R8: When bit 3i+2 is set, a capture on pin i sets status bit 4+i. `cap_irq` is the OR of the status bits.
- R9: Writing a 1 to status bit 4+i at address 2 clears that flag, and writing a 0 leaves it unchanged. A capture at the same edge wins over the clear.
- R10: Address 0 reads the mode field in bits 3:0, address 1 reads the capture controls in bits 11:0, address 2 reads the flags in bits 7:4, and address 4+i reads capture register i. Address 3 reads 0, and writes to addresses 4 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_in | input | 4 | Asynchronous capture and count pins |
| cnt_en | input | 1 | Counter enable |
| cnt_clr | input | 1 | Synchronous counter clear |
| presc_tick | input | 1 | Step pulse from the prescaler in timer mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tc_value | output | 32 | Timer counter |
| presc_hold | output | 1 | Holds the prescaler at zero in counter mode |
| cap_irq | output | 1 | OR of the capture flags |

## Verification
The assertions take for granted that `cnt_en`, `cnt_clr` and the register strobes are synchronous and stay stable across each rising edge. Only `cap_in` may change at arbitrary times. They also take for granted that the pins are low while reset is applied, so that no spurious rise event follows reset. The stimulus drives every input at the falling clock edge, holds `cap_in` low through reset, and toggles pins at random with each level lasting at least one full clock. As a result, the sampled history that a reference model computes matches what the synchronizer sees.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int DATA_W    = 32;
    localparam int MODE_W    = 4;
    localparam int CTL_PER   = 3;
    localparam int FLAG_LSB  = 4;
    localparam int ADDR_MODE = 0;
    localparam int ADDR_CTL  = 1;
    localparam int ADDR_STAT = 2;
    localparam int ADDR_CAP0 = 4;

    typedef enum logic [1:0] {
        CM_TIMER = 2'b00,
        CM_RISE  = 2'b01,
        CM_FALL  = 2'b10,
        CM_BOTH  = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        LV_LOW  = 1'b0,
        LV_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/tcap_edge_fsm.sv
module tcap_edge_fsm
    import tcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic ev_rise,
    output logic ev_fall
);
    logic sync_a, sync_b;
    lvl_e state_q, state_d;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= pin_async;
            sync_b <= sync_a;
        end
    end

    // state register: last accepted level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_LOW;
        else        state_q <= state_d;
    end

    // transitions and event outputs
    always_comb begin
        state_d = state_q;
        ev_rise = 1'b0;
        ev_fall = 1'b0;
        unique case (state_q)
            LV_LOW: begin
                if (sync_b) begin
                    state_d = LV_HIGH;
                    ev_rise = 1'b1;
                end
            end
            LV_HIGH: begin
                if (!sync_b) begin
                    state_d = LV_LOW;
                    ev_fall = 1'b1;
                end
            end
            default: state_d = LV_LOW;
        endcase
    end

    p_rise_lands_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rise |=> (state_q == LV_HIGH));
    p_fall_lands_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fall |=> (state_q == LV_LOW));
endmodule

// File: rtl/tcap_count_sel.sv
module tcap_count_sel
    import tcap_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SEL_W = 2
) (
    input  cnt_mode_e        mode,
    input  logic [SEL_W-1:0] pin_sel,
    input  logic [NCH-1:0]   rise,
    input  logic [NCH-1:0]   fall,
    input  logic             presc_tick,
    input  logic             cnt_en,
    output logic             step,
    output logic             presc_hold
);
    logic sel_rise, sel_fall;

    always_comb begin
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(pin_sel) == i) begin
                sel_rise = rise[i];
                sel_fall = fall[i];
            end
        end
    end

    always_comb begin
        step       = 1'b0;
        presc_hold = 1'b1;
        unique case (mode)
            CM_TIMER: begin
                step       = cnt_en & presc_tick;
                presc_hold = 1'b0;
            end
            CM_RISE: step = cnt_en & sel_rise;
            CM_FALL: step = cnt_en & sel_fall;
            CM_BOTH: step = cnt_en & (sel_rise | sel_fall);
            default: step = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcap_cap_chan.sv
module tcap_cap_chan #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_rise,
    input  logic          ev_fall,
    input  logic [2:0]    ctl,      // {irq_en, on_fall, on_rise}
    input  logic [TW-1:0] tc_now,
    input  logic          clr_w1,
    output logic [TW-1:0] cap_q,
    output logic          flag_q
);
    logic fire, set_flag;

    assign fire     = (ev_rise & ctl[0]) | (ev_fall & ctl[1]);
    assign set_flag = fire & ctl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_q <= '0;
        else if (fire) cap_q <= tc_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (set_flag) flag_q <= 1'b1;
        else if (clr_w1)   flag_q <= 1'b0;
    end

    p_capture_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_q == $past(tc_now)));
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag_q);
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w1 && !set_flag) |=> !flag_q);
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 32,
    parameter int AW  = 3,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NCH-1:0] cap_in,
    input  logic          cnt_en,
    input  logic          cnt_clr,
    input  logic          presc_tick,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [TW-1:0] tc_value,
    output logic          presc_hold,
    output logic          cap_irq
);
    localparam int CTL_W = CTL_PER * NCH;
    localparam int SEL_W = 2;

    logic [MODE_W-1:0] mode_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [TW-1:0]     tc_q;
    logic [NCH-1:0]    rise, fall, flag;
    logic [TW-1:0]     cap_q [NCH];
    logic              step;
    logic              wr_mode, wr_ctl, wr_stat;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:CTL_W];

    assign wr_mode = reg_we && (reg_addr == AW'(ADDR_MODE));
    assign wr_ctl  = reg_we && (reg_addr == AW'(ADDR_CTL));
    assign wr_stat = reg_we && (reg_addr == AW'(ADDR_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctl_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= reg_wdata[MODE_W-1:0];
            if (wr_ctl)  ctl_q  <= reg_wdata[CTL_W-1:0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tcap_edge_fsm u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (cap_in[g]),
            .ev_rise   (rise[g]),
            .ev_fall   (fall[g])
        );
        tcap_cap_chan #(.TW(TW)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_rise (rise[g]),
            .ev_fall (fall[g]),
            .ctl     (ctl_q[CTL_PER*g +: CTL_PER]),
            .tc_now  (tc_q),
            .clr_w1  (wr_stat & reg_wdata[FLAG_LSB+g]),
            .cap_q   (cap_q[g]),
            .flag_q  (flag[g])
        );
    end

    tcap_count_sel #(.NCH(NCH), .SEL_W(SEL_W)) u_sel (
        .mode       (cnt_mode_e'(mode_q[1:0])),
        .pin_sel    (mode_q[3:2]),
        .rise       (rise),
        .fall       (fall),
        .presc_tick (presc_tick),
        .cnt_en     (cnt_en),
        .step       (step),
        .presc_hold (presc_hold)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tc_q <= '0;
        else if (cnt_clr) tc_q <= '0;
        else if (step)    tc_q <= tc_q + 1'b1;
    end

    assign tc_value = tc_q;
    assign cap_irq  = |flag;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_MODE))      reg_rdata = DW'(mode_q);
        else if (reg_addr == AW'(ADDR_CTL))  reg_rdata = DW'(ctl_q);
        else if (reg_addr == AW'(ADDR_STAT)) reg_rdata = DW'(flag) << FLAG_LSB;
        else begin
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == AW'(ADDR_CAP0 + i)) reg_rdata = DW'(cap_q[i]);
            end
        end
    end

    p_step_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_clr) |=> (tc_value == $past(tc_value) + 1'b1));
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(tc_value));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (tc_value == '0));
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_hold && !(|rise) && !(|fall) && !cnt_clr) |=> $stable(tc_value));
endmodule

// File: tb/tb_tcap_unit.sv
`timescale 1ns/1ps
module tb_tcap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        cnt_en = 1'b0, cnt_clr = 1'b0, presc_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, tc_value;
    logic        presc_hold, cap_irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tcap_unit dut (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cnt_en(cnt_en),
        .cnt_clr(cnt_clr), .presc_tick(presc_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tc_value(tc_value), .presc_hold(presc_hold), .cap_irq(cap_irq)
    );

    // reference model, written from the requirements
    logic [3:0]  m_s1, m_s2, m_lv, m_flag, ev_r, ev_f, setf;
    logic [3:0]  m_mode;
    logic [11:0] m_ctl;
    logic [31:0] m_tc;
    logic [31:0] m_cap [4];
    logic        m_step;

    function automatic logic count_step(input logic [3:0] md, input logic [3:0] r,
                                        input logic [3:0] f, input logic tick, input logic en);
        logic [1:0] s;
        s = md[3:2];
        case (md[1:0])
            2'b00:   return en & tick;
            2'b01:   return en & r[s];
            2'b10:   return en & f[s];
            default: return en & (r[s] | f[s]);
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {28'b0, m_mode};
            3'd1: return {20'b0, m_ctl};
            3'd2: return {24'b0, m_flag, 4'b0};
            3'd4: return m_cap[0];
            3'd5: return m_cap[1];
            3'd6: return m_cap[2];
            3'd7: return m_cap[3];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_lv = '0; m_flag = '0;
            m_mode = '0; m_ctl = '0; m_tc = '0;
            for (int i = 0; i < 4; i++) m_cap[i] = '0;
        end else begin
            ev_r = m_s2 & ~m_lv;
            ev_f = ~m_s2 & m_lv;
            setf = '0;
            m_step = count_step(m_mode, ev_r, ev_f, presc_tick, cnt_en);
            for (int i = 0; i < 4; i++) begin
                if ((ev_r[i] & m_ctl[3*i]) | (ev_f[i] & m_ctl[3*i+1])) begin
                    m_cap[i] = m_tc;
                    setf[i] = m_ctl[3*i+2];
                end
                if (setf[i]) m_flag[i] = 1'b1;
                else if (reg_we && reg_addr == 3'd2 && reg_wdata[4+i]) m_flag[i] = 1'b0;
            end
            if (cnt_clr)     m_tc = '0;
            else if (m_step) m_tc = m_tc + 1;
            if (reg_we && reg_addr == 3'd0) m_mode = reg_wdata[3:0];
            if (reg_we && reg_addr == 3'd1) m_ctl = reg_wdata[11:0];
            m_lv = m_s2; m_s2 = m_s1; m_s1 = cap_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock; compare ports against the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        chk(m_mode[1:0] == 2'b00 ? "R2 tc" : "R4 tc", tc_value, m_tc);
        chk("R3 hold", {31'b0, presc_hold}, {31'b0, m_mode[1:0] != 2'b00});
        chk("R8 irq", {31'b0, cap_irq}, {31'b0, |m_flag});
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag);
        reg_we = 1'b0; reg_addr = a; #1;
        chk(tag, reg_rdata, m_read(a));
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] tc_before;
        void'($urandom(32'd7719));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 tc", tc_value, 32'h0);
        chk("R1 irq", {31'b0, cap_irq}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a); #1;
            chk("R1 rdata", reg_rdata, 32'h0);
        end
        cnt_en = 1'b1;

        // R5: count rising edges of pin 2; pin 0 must not count
        wr(3'd0, 32'h9);
        cap_in[0] = 1'b1;
        idle(5);
        chk("R5 other pin", tc_value, 32'h0);
        cap_in[2] = 1'b1;
        idle(2);
        chk("R4 latency edge k+1", tc_value, 32'h0);
        idle(1);
        chk("R4 rise counted", tc_value, 32'h1);

        // R7/R8: fall on pin 2, both-edge counting, capture holds pre-count value
        wr(3'd0, 32'hB);
        wr(3'd1, 32'h180);
        tc_before = tc_value;
        cap_in[2] = 1'b0;
        idle(3);
        chk("R4 fall counted", tc_value, tc_before + 1);
        rd_chk(3'd6, "R7 capture");
        chk("R7 capture value", reg_rdata, tc_before);
        chk("R8 irq set", {31'b0, cap_irq}, 32'h1);
        rd_chk(3'd2, "R8 status");

        // R9: zero write keeps the flag, one write clears it
        wr(3'd2, 32'h0);
        chk("R9 zero write", {31'b0, cap_irq}, 32'h1);
        wr(3'd2, 32'h40);
        chk("R9 one write", {31'b0, cap_irq}, 32'h0);

        // R10: capture registers are read-only
        wr(3'd6, 32'hDEAD_BEEF);
        rd_chk(3'd6, "R10 cap readonly");
        rd_chk(3'd3, "R10 hole");

        // R3/R6: ticks ignored in counter mode, freeze, clear
        tc_before = tc_value;
        presc_tick = 1'b1;
        idle(4);
        chk("R3 tick ignored", tc_value, tc_before);
        wr(3'd0, 32'h0);
        cnt_en = 1'b0;
        idle(4);
        chk("R6 freeze", tc_value, tc_before);
        cnt_en = 1'b1;
        idle(3);
        chk("R2 timer count", tc_value, tc_before + 3);
        cnt_clr = 1'b1;
        idle(1);
        cnt_clr = 1'b0;
        chk("R6 clear", tc_value, 32'h0);

        // constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 4; i++)
                if ($urandom_range(5) == 0) cap_in[i] = ~cap_in[i];
            presc_tick = 1'($urandom_range(1));
            cnt_en     = ($urandom_range(9) != 0);
            cnt_clr    = ($urandom_range(199) == 0);
            if ($urandom_range(11) == 0) begin
                reg_we = 1'b1;
                reg_addr = 3'($urandom_range(7));
                reg_wdata = $urandom;
            end else begin
                reg_we = 1'b0;
                reg_addr = 3'($urandom_range(7));
            end
            #1;
            chk(reg_addr >= 3'd4 ? "R7 rd cap" : (reg_addr == 3'd2 ? "R9 rd stat" : "R10 rd"),
                reg_rdata, m_read(reg_addr));
            cyc();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule